// File: doc/BRIEF.md
# Lockable Instruction/Data Translation Buffer Pair

This block holds two small fully associative translation buffers side by side, one serving instruction fetches and one serving data accesses. Each entry maps a virtual page number to a physical page number and carries a cacheable attribute and a lock bit. A maintenance port loads entries, locks and unlocks them, and invalidates them. An invalidate can clear a single entry, one whole buffer, or both buffers together. Locked entries survive a whole-buffer invalidate. New entries are placed round-robin, and locked slots are skipped.

A lookup presents a side select and a virtual page number. The result appears on the response outputs one clock later. A small configuration register holds a translation enable and a data-cache enable. With translation off, the page number passes through unchanged. Instruction accesses are then reported cacheable and data accesses non-cacheable. Setting the data-cache enable while translation is off is an illegal pairing, and it is flagged on an error output.

A single-entry invalidate aimed at a locked entry leaves a dead slot. That slot no longer hits but stays reserved. The slot becomes free again only when it is unlocked.

Top module: `tlb_pair`

## Requirements
- R1: After reset, translation and the data-cache enable are off, every entry in both buffers is invalid and unlocked, the round-robin pointers are 0, and rsp_valid, op_err and cfg_err are low.
- R2: A cycle with cfg_we high loads cfg_wdata into the configuration register. Bit 0 is the translation enable and bit 1 is the data-cache enable. A lookup in the same cycle still uses the old value, and lookups from the next cycle use the new one.
- R3: With translation off, a lookup returns, one cycle later, rsp_valid=1, rsp_hit=1 and rsp_ppn equal to the looked-up page. rsp_cacheable is 1 on the instruction side (lk_side=0) and 0 on the data side (lk_side=1).
- R4: cfg_err is high exactly while the data-cache enable is set and translation is clear, and data lookups stay non-cacheable in that state.
- R5: With translation on, a lookup that matches a valid entry of the selected buffer returns rsp_hit=1 with that entry's page. The attribute is returned as stored on the instruction side, and ANDed with the data-cache enable on the data side. A miss returns rsp_hit=0, rsp_ppn=0 and rsp_cacheable=0. A cycle with no lookup returns all response outputs low.
- R6: op_sel bit 0 targets the instruction buffer and bit 1 the data buffer, and both bits together target both. Operation code 1 (invalidate all) clears the valid bit of every unlocked entry in each targeted buffer and leaves locked entries valid and locked.
- R7: Code 2 (invalidate one) clears the valid bit of the valid entry whose page matches op_vpn and keeps its lock bit. Such a locked dead slot never hits and is never chosen for a new entry.
- R8: Code 3 (lock) sets the lock bit of the valid entry matching op_vpn, and has no effect when there is no match. Code 4 (unlock) clears the lock bit of every locked entry whose stored page matches op_vpn, which frees a dead slot for reuse.
- R9: Code 5 (load) overwrites the page and attribute of a valid entry whose page already matches op_vpn, and sets its lock bit if op_lock is set. Without a match it writes the first unlocked slot at or after the buffer's round-robin pointer, wrapping around. That slot becomes valid, is locked iff op_lock is set, and the pointer moves to the slot after it.
- R10: A load without a match in a buffer whose slots are all locked changes nothing in that buffer, and op_err is high for the one cycle after the request. A load that targets both buffers still completes in the buffer that has room.
- R11: A maintenance operation issued in the same cycle as a lookup affects only lookups from the next cycle onward. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 2 | Bit 0 translation enable, bit 1 data-cache enable |
| cfg_err | output | 1 | Illegal configuration (data cache on, translation off) |
| op_valid | input | 1 | Maintenance operation request |
| op_code | input | 3 | 0 none, 1 invalidate all, 2 invalidate one, 3 lock, 4 unlock, 5 load |
| op_sel | input | 2 | Target buffers: bit 0 instruction, bit 1 data |
| op_vpn | input | PAGE_W | Virtual page for match or load |
| op_ppn | input | PAGE_W | Physical page to load |
| op_cacheable | input | 1 | Attribute to load |
| op_lock | input | 1 | Lock the loaded entry |
| op_err | output | 1 | One-cycle pulse: load rejected, all slots locked |
| lk_valid | input | 1 | Lookup request |
| lk_side | input | 1 | 0 instruction buffer, 1 data buffer |
| lk_vpn | input | PAGE_W | Virtual page to translate |
| rsp_valid | output | 1 | Registered lookup response valid |
| rsp_hit | output | 1 | Translation found (always 1 in pass-through) |
| rsp_ppn | output | PAGE_W | Translated page |
| rsp_cacheable | output | 1 | Cacheable attribute of the access |

## Verification
A lookup and a maintenance operation, or a lookup and a configuration write, can fall in the same cycle. The response must then reflect the state before the edge. The bench provokes this by loading, invalidating or unlocking a page while looking up that same page in the same cycle. It does the same with a configuration write, where the lookup must come back as a miss, as a pass-through or as a hit according to the old state. A behavioural reference model applies the lookup first and the operation afterwards, and its result is compared with the response outputs on every clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_INV_ALL = 3'd1,
    OP_INV_ONE = 3'd2,
    OP_LOCK    = 3'd3,
    OP_UNLOCK  = 3'd4,
    OP_LOAD    = 3'd5
  } tlb_op_e;

  // Attribute reported when translation is bypassed: instruction side only.
  function automatic logic bypass_cacheable(input logic side_is_data);
    return !side_is_data;
  endfunction

  // Attribute of a translated hit: data side is gated by the data-cache enable.
  function automatic logic hit_cacheable(input logic side_is_data,
                                         input logic stored,
                                         input logic dcache_on);
    return side_is_data ? (stored & dcache_on) : stored;
  endfunction

endpackage

// File: rtl/tlb_rr_pick.sv
module tlb_rr_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] avail,
  input  logic [IDX_W-1:0]   start,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] cand;

  // First available slot at or after start, wrapping (ENTRIES is a power of two).
  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      cand = start + IDX_W'(k);
      if (!found && avail[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PAGE_W  = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_en,
  input  logic [2:0]         op_code,
  input  logic [PAGE_W-1:0]  op_vpn,
  input  logic [PAGE_W-1:0]  op_ppn,
  input  logic               op_c,
  input  logic               op_lock,
  input  logic [PAGE_W-1:0]  lk_vpn,
  output logic               lk_hit,
  output logic [PAGE_W-1:0]  lk_ppn,
  output logic               lk_c,
  output logic               load_reject,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] lock_o
);
  logic [ENTRIES-1:0] valid_q, lock_q, attr_q;
  logic [PAGE_W-1:0]  tag_q [ENTRIES];
  logic [PAGE_W-1:0]  ppn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] op_tag_eq, op_match, lk_match;
  logic               present;
  logic [IDX_W-1:0]   present_idx;
  logic               vic_found;
  logic [IDX_W-1:0]   vic_idx;
  logic               load_req, wr_en;
  logic [IDX_W-1:0]   wr_idx;
  tlb_op_e            op;

  assign op = tlb_op_e'(op_code);

  always_comb begin
    present     = 1'b0;
    present_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      op_tag_eq[i] = (tag_q[i] == op_vpn);
      op_match[i]  = valid_q[i] & op_tag_eq[i];
      lk_match[i]  = valid_q[i] & (tag_q[i] == lk_vpn);
      if (op_match[i] && !present) begin
        present     = 1'b1;
        present_idx = IDX_W'(i);
      end
    end
  end

  // Valid tags are unique, so an OR over the match vector selects one entry.
  always_comb begin
    lk_ppn = '0;
    lk_c   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn = lk_ppn | ppn_q[i];
        lk_c   = lk_c | attr_q[i];
      end
    end
  end
  assign lk_hit = |lk_match;

  tlb_rr_pick #(.ENTRIES(ENTRIES)) u_pick (
    .avail (~lock_q),
    .start (ptr_q),
    .found (vic_found),
    .idx   (vic_idx)
  );

  assign load_req    = op_en && (op == OP_LOAD);
  assign load_reject = load_req && !present && !vic_found;
  assign wr_en       = load_req && (present || vic_found);
  assign wr_idx      = present ? present_idx : vic_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      ptr_q   <= '0;
    end else if (op_en) begin
      case (op)
        OP_INV_ALL: valid_q <= valid_q & lock_q;
        OP_INV_ONE: valid_q <= valid_q & ~op_match;
        OP_LOCK:    lock_q  <= lock_q | op_match;
        OP_UNLOCK:  lock_q  <= lock_q & ~op_tag_eq;
        OP_LOAD: begin
          if (present) begin
            lock_q[present_idx] <= lock_q[present_idx] | op_lock;
          end else if (vic_found) begin
            valid_q[vic_idx] <= 1'b1;
            lock_q[vic_idx]  <= op_lock;
            ptr_q            <= vic_idx + IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= op_vpn;
      ppn_q[wr_idx]  <= op_ppn;
      attr_q[wr_idx] <= op_c;
    end
  end

  assign valid_o = valid_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/tlb_pair.sv
module tlb_pair
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PAGE_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wdata,
  output logic              cfg_err,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [1:0]        op_sel,
  input  logic [PAGE_W-1:0] op_vpn,
  input  logic [PAGE_W-1:0] op_ppn,
  input  logic              op_cacheable,
  input  logic              op_lock,
  output logic              op_err,
  input  logic              lk_valid,
  input  logic              lk_side,
  input  logic [PAGE_W-1:0] lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PAGE_W-1:0] rsp_ppn,
  output logic              rsp_cacheable
);
  localparam int NBANK = 2;

  logic xlat_on_q, dcache_on_q;

  logic [NBANK-1:0]              bank_hit, bank_c, bank_reject;
  logic [PAGE_W-1:0]             bank_ppn [NBANK];
  logic [NBANK-1:0][ENTRIES-1:0] valid_v, lock_v;

  logic              nx_hit, nx_c;
  logic [PAGE_W-1:0] nx_ppn;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    tlb_bank #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_en       (op_valid && op_sel[b]),
      .op_code     (op_code),
      .op_vpn      (op_vpn),
      .op_ppn      (op_ppn),
      .op_c        (op_cacheable),
      .op_lock     (op_lock),
      .lk_vpn      (lk_vpn),
      .lk_hit      (bank_hit[b]),
      .lk_ppn      (bank_ppn[b]),
      .lk_c        (bank_c[b]),
      .load_reject (bank_reject[b]),
      .valid_o     (valid_v[b]),
      .lock_o      (lock_v[b])
    );
  end

  always_comb begin
    if (!xlat_on_q) begin
      nx_hit = 1'b1;
      nx_ppn = lk_vpn;
      nx_c   = bypass_cacheable(lk_side);
    end else begin
      nx_hit = bank_hit[lk_side];
      nx_ppn = bank_hit[lk_side] ? bank_ppn[lk_side] : '0;
      nx_c   = bank_hit[lk_side] &&
               hit_cacheable(lk_side, bank_c[lk_side], dcache_on_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlat_on_q     <= 1'b0;
      dcache_on_q   <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_ppn       <= '0;
      rsp_cacheable <= 1'b0;
      op_err        <= 1'b0;
    end else begin
      if (cfg_we) begin
        xlat_on_q   <= cfg_wdata[0];
        dcache_on_q <= cfg_wdata[1];
      end
      rsp_valid     <= lk_valid;
      rsp_hit       <= lk_valid && nx_hit;
      rsp_ppn       <= lk_valid ? nx_ppn : '0;
      rsp_cacheable <= lk_valid && nx_c;
      op_err        <= |bank_reject;
    end
  end

  assign cfg_err = dcache_on_q && !xlat_on_q;
endmodule

// File: rtl/tlb_pair_chk.sv
module tlb_pair_chk #(
  parameter int ENTRIES = 32,
  parameter int PAGE_W  = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid,
  input logic [2:0]              op_code,
  input logic [1:0]              op_sel,
  input logic                    lk_valid,
  input logic                    lk_side,
  input logic [PAGE_W-1:0]       lk_vpn,
  input logic                    rsp_valid,
  input logic                    rsp_hit,
  input logic [PAGE_W-1:0]       rsp_ppn,
  input logic                    rsp_cacheable,
  input logic                    op_err,
  input logic                    xlat_on,
  input logic [1:0][ENTRIES-1:0] valid_v,
  input logic [1:0][ENTRIES-1:0] lock_v,
  input logic [1:0]              bank_reject
);
  // R3
  bypass_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xlat_on) |=> (rsp_hit && rsp_ppn == $past(lk_vpn)));

  // R3
  bypass_data_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_side && !xlat_on) |=> !rsp_cacheable);

  // R5
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_cacheable && rsp_ppn == '0));

  // R6
  flush_keeps_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && op_sel[1]) |=> (lock_v[1] == $past(lock_v[1])));

  // R6
  flush_clears_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && op_sel[0]) |=> ((valid_v[0] & ~lock_v[0]) == '0));

  // R7
  single_inv_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2 && op_sel[1]) |=> (lock_v[1] == $past(lock_v[1])));

  // R10
  err_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> $past(op_valid && op_code == 3'd5));

  // R10
  reject_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_reject[0] |-> (&lock_v[0]));
endmodule

bind tlb_pair tlb_pair_chk #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .op_code       (op_code),
  .op_sel        (op_sel),
  .lk_valid      (lk_valid),
  .lk_side       (lk_side),
  .lk_vpn        (lk_vpn),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_ppn       (rsp_ppn),
  .rsp_cacheable (rsp_cacheable),
  .op_err        (op_err),
  .xlat_on       (xlat_on_q),
  .valid_v       (valid_v),
  .lock_v        (lock_v),
  .bank_reject   (bank_reject)
);

// File: tb/tlb_pair_test.sv
`timescale 1ns/1ps
module tlb_pair_test;
  localparam int ENT = 32;
  localparam int PW  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_wdata = '0;
  logic          cfg_err;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [1:0]    op_sel = '0;
  logic [PW-1:0] op_vpn = '0, op_ppn = '0;
  logic          op_cacheable = 1'b0, op_lock = 1'b0;
  logic          op_err;
  logic          lk_valid = 1'b0, lk_side = 1'b0;
  logic [PW-1:0] lk_vpn = '0;
  logic          rsp_valid, rsp_hit, rsp_cacheable;
  logic [PW-1:0] rsp_ppn;

  always #4 clk = ~clk;

  tlb_pair #(.ENTRIES(ENT), .PAGE_W(PW)) uut (.*);

  int    n_chk = 0, n_fail = 0, ctr = 0;
  bit    done = 0, man_lk = 0;
  string cur_req = "R1";

  // reference model state
  bit            m_val [2][ENT];
  bit            m_lck [2][ENT];
  logic [PW-1:0] m_tag [2][ENT];
  logic [PW-1:0] m_ppn [2][ENT];
  bit            m_c   [2][ENT];
  int            m_ptr [2];
  bit            m_x = 0, m_d = 0;
  bit            e_rv = 0, e_hit = 0, e_c = 0, e_err = 0;
  logic [PW-1:0] e_ppn = '0;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  function automatic int find_live(input int b, input logic [PW-1:0] v);
    for (int i = 0; i < ENT; i++) if (m_val[b][i] && m_tag[b][i] == v) return i;
    return -1;
  endfunction

  task automatic apply_op(input int b, inout bit rej);
    int hit;
    int slot;
    case (op_code)
      3'd1: for (int i = 0; i < ENT; i++) if (!m_lck[b][i]) m_val[b][i] = 0;
      3'd2: begin hit = find_live(b, op_vpn); if (hit >= 0) m_val[b][hit] = 0; end
      3'd3: begin hit = find_live(b, op_vpn); if (hit >= 0) m_lck[b][hit] = 1; end
      3'd4: for (int i = 0; i < ENT; i++) if (m_lck[b][i] && m_tag[b][i] == op_vpn) m_lck[b][i] = 0;
      3'd5: begin
        hit = find_live(b, op_vpn);
        if (hit >= 0) begin
          m_ppn[b][hit] = op_ppn; m_c[b][hit] = op_cacheable;
          if (op_lock) m_lck[b][hit] = 1;
        end else begin
          slot = -1;
          for (int s = 0; s < ENT && slot < 0; s++)
            if (!m_lck[b][(m_ptr[b] + s) % ENT]) slot = (m_ptr[b] + s) % ENT;
          if (slot < 0) rej = 1;
          else begin
            m_val[b][slot] = 1; m_lck[b][slot] = op_lock; m_tag[b][slot] = op_vpn;
            m_ppn[b][slot] = op_ppn; m_c[b][slot] = op_cacheable;
            m_ptr[b] = (slot + 1) % ENT;
          end
        end
      end
      default: ;
    endcase
  endtask

  // lookup sees the pre-edge state, then the operation and config write apply
  task automatic model_edge();
    int s;
    int hit;
    bit rej;
    s = int'(lk_side);
    e_rv = lk_valid; e_hit = 0; e_ppn = '0; e_c = 0;
    if (lk_valid) begin
      if (!m_x) begin e_hit = 1; e_ppn = lk_vpn; e_c = (s == 0); end
      else begin
        hit = find_live(s, lk_vpn);
        if (hit >= 0) begin
          e_hit = 1; e_ppn = m_ppn[s][hit];
          e_c = (s == 0) ? m_c[s][hit] : (m_c[s][hit] && m_d);
        end
      end
    end
    rej = 0;
    if (op_valid) for (int b = 0; b < 2; b++) if (op_sel[b]) apply_op(b, rej);
    e_err = rej;
    if (cfg_we) begin m_x = cfg_wdata[0]; m_d = cfg_wdata[1]; end
  endtask

  task automatic tick();
    if (!man_lk) begin
      lk_valid = (ctr % 5) != 4;
      lk_side  = ctr[0];
      lk_vpn   = PW'((ctr >> 1) % 48);
      ctr++;
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({rsp_valid, rsp_hit, rsp_cacheable} == {e_rv, e_hit, e_c}, "rsp flags",
          64'({rsp_valid, rsp_hit, rsp_cacheable}), 64'({e_rv, e_hit, e_c}));
    check(rsp_ppn == e_ppn, "rsp_ppn", 64'(rsp_ppn), 64'(e_ppn));
    check({op_err, cfg_err} == {e_err, m_d && !m_x}, "op_err/cfg_err",
          64'({op_err, cfg_err}), 64'({e_err, m_d && !m_x}));
    op_valid = 0; cfg_we = 0; man_lk = 0; op_lock = 0;
  endtask

  task automatic do_op(input logic [2:0] code, input logic [1:0] sel, input int vpn,
                       input int ppn, input bit c, input bit lk);
    op_valid = 1; op_code = code; op_sel = sel; op_vpn = PW'(vpn);
    op_ppn = PW'(ppn); op_cacheable = c; op_lock = lk;
    tick();
  endtask

  task automatic set_lk(input bit side, input int vpn);
    man_lk = 1; lk_valid = 1; lk_side = side; lk_vpn = PW'(vpn);
  endtask

  task automatic look(input bit side, input int vpn);
    set_lk(side, vpn);
    tick();
  endtask

  task automatic cfg(input logic [1:0] v);
    cfg_we = 1; cfg_wdata = v;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_ptr[b] = 0;
      for (int i = 0; i < ENT; i++) begin
        m_val[b][i] = 0; m_lck[b][i] = 0; m_tag[b][i] = '0; m_ppn[b][i] = '0; m_c[b][i] = 0;
      end
    end
    repeat (4) @(negedge clk);
    cur_req = "R1";
    check({rsp_valid, op_err, cfg_err} == 3'b000, "reset outputs", 64'({rsp_valid, op_err, cfg_err}), 0);
    rst_n = 1;
    // R1: right after reset translation is off (pass-through), then all entries miss
    look(1, 5);
    cfg(2'b01);
    for (int v = 0; v < 6; v++) look(v[0], v);

    // R3: pass-through on both sides
    cur_req = "R3";
    cfg(2'b00);
    for (int v = 0; v < 8; v++) look(v[0], 1000 + v);

    // R2: config write and lookup in the same cycle use the old setting
    cur_req = "R2";
    set_lk(0, 77); cfg(2'b01);
    look(0, 77);
    set_lk(1, 78); cfg(2'b00);
    look(1, 78);

    // R4: illegal pairing flagged, data stays non-cacheable
    cur_req = "R4";
    cfg(2'b10);
    look(1, 9); look(0, 9); tick();
    cfg(2'b11);

    // R5: loaded translations on both sides, data attribute gated by enable
    cur_req = "R5";
    for (int v = 0; v < 16; v++) do_op(3'd5, 2'b01, v, 'h100 + v, v[0], 0);
    for (int v = 0; v < 16; v++) do_op(3'd5, 2'b10, v, 'h200 + 3 * v, 1, 0);
    for (int v = 0; v < 20; v++) look(v[0], v);
    cfg(2'b01);
    for (int v = 0; v < 6; v++) look(1, v);
    cfg(2'b11);
    do_op(3'd0, 2'b11, 3, 0, 0, 0);
    look(0, 3); look(1, 3);

    // R11: load and lookup of the same page in one cycle, then again
    cur_req = "R11";
    set_lk(1, 30); do_op(3'd5, 2'b10, 30, 'h330, 1, 0);
    look(1, 30);
    set_lk(1, 30); do_op(3'd2, 2'b10, 30, 0, 0, 0);
    look(1, 30);

    // R9: overwrite in place, then round-robin wrap over the data buffer
    cur_req = "R9";
    do_op(3'd5, 2'b10, 3, 'hABC, 0, 0);
    look(1, 3);
    for (int v = 100; v < 140; v++) do_op(3'd5, 2'b10, v, 'h4000 + v, 1, 0);
    for (int v = 0; v < 16; v++) look(1, v);
    for (int v = 100; v < 140; v++) look(1, v);

    // R8: lock present pages, lock of an absent page does nothing
    cur_req = "R8";
    for (int v = 130; v < 134; v++) do_op(3'd3, 2'b10, v, 0, 0, 0);
    do_op(3'd3, 2'b10, 999, 0, 0, 0);

    // R6: flush only instructions, then both
    cur_req = "R6";
    do_op(3'd1, 2'b01, 0, 0, 0, 0);
    for (int v = 0; v < 6; v++) look(0, v);
    look(1, 131);
    do_op(3'd1, 2'b11, 0, 0, 0, 0);
    for (int v = 126; v < 136; v++) look(1, v);

    // R7: single invalidate of a locked page leaves a dead reserved slot
    cur_req = "R7";
    do_op(3'd2, 2'b10, 131, 0, 0, 0);
    look(1, 131);
    for (int v = 200; v < 240; v++) do_op(3'd5, 2'b10, v, 'h5000 + v, 1, 0);
    for (int v = 200; v < 240; v++) look(1, v);
    look(1, 130); look(1, 131);

    // R8: unlock frees the dead slot and unlocks a live one
    cur_req = "R8";
    do_op(3'd4, 2'b10, 131, 0, 0, 0);
    for (int v = 300; v < 340; v++) do_op(3'd5, 2'b10, v, 'h6000 + v, 0, 0);
    for (int v = 300; v < 340; v++) look(1, v);
    do_op(3'd4, 2'b10, 130, 0, 0, 0);
    do_op(3'd1, 2'b10, 0, 0, 0, 0);
    look(1, 130); look(1, 132);

    // R10: fill the instruction buffer with locked entries, then overflow
    cur_req = "R10";
    for (int v = 400; v < 432; v++) do_op(3'd5, 2'b01, v, 'h7000 + v, 1, 1);
    do_op(3'd5, 2'b01, 500, 'h7500, 1, 0);
    tick();
    do_op(3'd5, 2'b01, 410, 'h7777, 0, 0);
    look(0, 410); look(0, 500);
    do_op(3'd5, 2'b11, 600, 'h7600, 1, 0);
    look(1, 600); look(0, 600);
    do_op(3'd1, 2'b01, 0, 0, 0, 0);
    look(0, 420);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule